// File: doc/BRIEF.md
# Microcontroller Clock Output Controller

This block generates the clock that a companion microcontroller runs from. It works from a phase clock at twice the crystal reference rate (60 MHz nominal for a 30 MHz reference) and, from a 3-bit code, produces one of seven divided frequencies. The eighth code passes through a separate 32.768 kHz low-frequency clock. Each output phase is a whole number of phase-clock cycles, so every divided option, including the 7.5:1 ratio behind 4 MHz, comes straight from a register.

When the chip goes to sleep, one of two things happens. With the low-frequency enable set, the output moves to the 32.768 kHz clock. With it clear, the output keeps running for a programmable number of extra rising edges (the tail) and then stops low. A pending interrupt overrides a sleep request: the selected clock keeps running and the oscillator enable stays high until the interrupt is read. Every change of source and every gating step happens while the output is low, so the output never carries a runt high pulse.

The control machine has seven states. RUN drives the selected clock. TAIL drives it while counting the tail edges. OFF holds the output low with the oscillator disabled. WAKE waits, with the oscillator enabled, for a low phase of the selected clock. LF_ENTER waits for a common low phase before the low-frequency clock takes over. LF drives the low-frequency clock with the oscillator disabled. LF_EXIT keeps driving it with the oscillator enabled until a common low phase allows the return to RUN. Let effective sleep mean sleep requested and no interrupt pending. The transitions are:
- RUN to TAIL, on effective sleep with the enable clear.
- RUN or TAIL to LF_ENTER, on effective sleep with the enable set.
- TAIL to RUN, when effective sleep ends.
- TAIL to OFF, once the tail count is zero and the output is low.
- OFF to WAKE, when effective sleep ends.
- OFF to LF, when the enable is set and the low-frequency clock is low.
- WAKE to RUN, at a low phase of the selected clock.
- LF_ENTER to RUN, when its condition ends.
- LF_ENTER to LF, at a common low phase.
- LF to LF_EXIT, when effective sleep or the enable drops.
- LF_EXIT to RUN, at a common low phase.

Top module: `mclk_out_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, mclk_o is low and osc_en_o is high (state RUN).
- R2: Select codes 0 to 6 give output periods of 2, 4, 6, 15, 20, 30 and 60 phase-clock cycles (30, 15, 10, 4, 3, 2 and 1 MHz). The high phase is floor(P/2) cycles and the low phase is the rest, so code 3 gives 7 high and 8 low.
- R3: Select code 7 makes mclk_o follow the low-frequency clock, delayed by a synchronizer, in sleep and awake alike.
- R4: Control byte layout: bits [2:0] hold the select code, bit 3 the low-frequency-in-sleep enable, and bits [5:4] the tail code. Bits [7:6] have no effect. The value 06h gives 1 MHz with no tail and no substitution.
- R5: In effective sleep with the enable set, mclk_o follows the low-frequency clock and osc_en_o is low. When sleep ends, osc_en_o rises and the selected clock returns.
- R6: In effective sleep with the enable clear, mclk_o shows exactly 0, 128, 256 or 512 rising edges for tail codes 0, 1, 2 and 3. After those edges it is held low and osc_en_o goes low.
- R7: If sleep ends before the tail has run out, the count is discarded. The next sleep starts a full tail again.
- R8: While the interrupt is pending, a sleep request has no effect: the selected clock runs and osc_en_o is high one cycle after the interrupt rises. Once the interrupt clears, the sleep sequence runs.
- R9: A source change or a gating step never shortens a high phase. Every high phase of mclk_o is a complete high phase of its source.
- R10: A change of select code does not alter a high phase already in progress. The new code governs from the next low phase onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Phase clock at twice the reference rate |
| rst_ni | input | 1 | Active-low reset |
| lf_clk_i | input | 1 | 32.768 kHz low-frequency clock, asynchronous |
| ctrl_i | input | 8 | Control byte (see R4) |
| sleep_i | input | 1 | Sleep requested |
| irq_pend_i | input | 1 | Interrupt pending, low once read |
| mclk_o | output | 1 | Clock to the microcontroller |
| osc_en_o | output | 1 | Reference oscillator may run |

## Verification
A divider counter or latched code that has gone wrong changes a high or low phase width within one output period, and the bench measures phase widths in phase-clock cycles exactly. A control state that goes wrong shows up as osc_en_o at the wrong level, or as the wrong clock source, within a few phase-clock cycles of a sleep or interrupt change. Both are checked right after each change. A tail counter that loads or counts wrongly shows up as a wrong number of output rising edges before osc_en_o falls. That count is checked as an exact edge total for each tail code and again after a sleep that ends early.

// File: rtl/mclk_ctrl_pkg.sv
package mclk_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_TAIL,
        ST_OFF,
        ST_WAKE,
        ST_LF_ENTER,
        ST_LF,
        ST_LF_EXIT
    } mc_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_SEL,
        SRC_LF
    } mc_src_e;

    localparam logic [2:0] CODE_LF = 3'd7;

    // Which clock source each state drives onto the output.
    function automatic mc_src_e src_of(input mc_state_e s);
        case (s)
            ST_RUN, ST_TAIL, ST_LF_ENTER: return SRC_SEL;
            ST_LF, ST_LF_EXIT:            return SRC_LF;
            default:                      return SRC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mclk_sync.sv
module mclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q <= '0;
                else         sh_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q <= '0;
                else         sh_q <= {sh_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/mclk_div_gen.sv
module mclk_div_gen
    import mclk_ctrl_pkg::*;
#(
    parameter int unsigned REF_KHZ = 30000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] code_i,
    input  logic       lf_i,
    output logic       lvl_o
);

    localparam int unsigned MAX_P = (2 * REF_KHZ) / 1000;
    localparam int unsigned CNT_W = $clog2(MAX_P / 2 + 1);

    function automatic int unsigned tgt_khz(input logic [2:0] c);
        case (c)
            3'd0:    return REF_KHZ;
            3'd1:    return REF_KHZ / 2;
            3'd2:    return REF_KHZ / 3;
            3'd3:    return 4000;
            3'd4:    return 3000;
            3'd5:    return 2000;
            default: return 1000;
        endcase
    endfunction

    function automatic int unsigned period_of(input logic [2:0] c);
        return (2 * REF_KHZ) / tgt_khz(c);
    endfunction

    function automatic logic [CNT_W-1:0] hi_last(input logic [2:0] c);
        return CNT_W'(period_of(c) / 2 - 1);
    endfunction

    function automatic logic [CNT_W-1:0] lo_last(input logic [2:0] c);
        return CNT_W'(period_of(c) - period_of(c) / 2 - 1);
    endfunction

    logic             lvl_q;
    logic             lf_mode_q;
    logic             arm_q;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       code_q;
    logic             lf_next;

    assign lf_next = lf_i & arm_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lvl_q     <= 1'b0;
            lf_mode_q <= 1'b0;
            arm_q     <= 1'b0;
            cnt_q     <= '0;
            code_q    <= 3'd6;
        end else if (lf_mode_q) begin
            if (code_i != CODE_LF && !lvl_q && !lf_next) begin
                // Leave pass-through during a common low phase.
                lf_mode_q <= 1'b0;
                lvl_q     <= 1'b0;
                code_q    <= code_i;
                cnt_q     <= lo_last(code_i);
            end else begin
                lvl_q <= lf_next;
                arm_q <= arm_q | ~lf_i;
            end
        end else if (cnt_q == '0) begin
            if (lvl_q) begin
                lvl_q <= 1'b0;
                if (code_i == CODE_LF) begin
                    lf_mode_q <= 1'b1;
                    arm_q     <= 1'b0;
                end else begin
                    code_q <= code_i;
                    cnt_q  <= lo_last(code_i);
                end
            end else begin
                lvl_q <= 1'b1;
                cnt_q <= hi_last(code_q);
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign lvl_o = lvl_q;

    // R2: the divider level only moves when its phase counter has expired
    a_r2_edge_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_q != $past(lvl_q)) && !$past(lf_mode_q) |-> $past(cnt_q) == '0);

    // R2: phase counter never exceeds the longest phase
    a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(cnt_q) < int'(MAX_P / 2));

    // R10: a latched code only changes while the level is low
    a_r10_code_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_q != $past(code_q)) |-> !lvl_q);

endmodule

// File: rtl/mclk_tail_cnt.sv
module mclk_tail_cnt #(
    parameter int unsigned TAIL_UNIT = 128
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic [1:0] sel_i,
    input  logic       tick_i,
    output logic       zero_o
);

    localparam int unsigned TAIL_W = $clog2(4 * TAIL_UNIT + 1);

    function automatic logic [TAIL_W-1:0] tail_len(input logic [1:0] s);
        case (s)
            2'd0:    return '0;
            2'd1:    return TAIL_W'(TAIL_UNIT);
            2'd2:    return TAIL_W'(2 * TAIL_UNIT);
            default: return TAIL_W'(4 * TAIL_UNIT);
        endcase
    endfunction

    logic [TAIL_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      cnt_q <= '0;
        else if (load_i)                  cnt_q <= tail_len(sel_i);
        else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R7: a load always leaves a full count for the next sleep
    a_r7_full_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && sel_i != 2'd0 |=> !zero_o);

endmodule

// File: rtl/mclk_out_ctrl.sv
module mclk_out_ctrl
    import mclk_ctrl_pkg::*;
#(
    parameter int unsigned REF_KHZ     = 30000,
    parameter int unsigned TAIL_UNIT   = 128,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lf_clk_i,
    input  logic [7:0] ctrl_i,
    input  logic       sleep_i,
    input  logic       irq_pend_i,
    output logic       mclk_o,
    output logic       osc_en_o
);

    // Control byte fields
    logic [2:0] sel_code;
    logic       lf_en;
    logic [1:0] tail_code;
    logic       ctrl_unused;

    assign sel_code    = ctrl_i[2:0];
    assign lf_en       = ctrl_i[3];
    assign tail_code   = ctrl_i[5:4];
    assign ctrl_unused = ^ctrl_i[7:6];

    logic      lf_s;
    logic      gen_lvl;
    logic      tail_zero;
    logic      tail_load;
    logic      tail_tick;
    logic      eff_sleep;
    logic      out_d;
    logic      out_q;
    mc_state_e state_q;
    mc_state_e state_d;

    mclk_sync #(
        .STAGES(SYNC_STAGES)
    ) lf_sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (lf_clk_i),
        .q_o    (lf_s)
    );

    mclk_div_gen #(
        .REF_KHZ(REF_KHZ)
    ) gen_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .code_i (sel_code),
        .lf_i   (lf_s),
        .lvl_o  (gen_lvl)
    );

    mclk_tail_cnt #(
        .TAIL_UNIT(TAIL_UNIT)
    ) tail_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tail_load),
        .sel_i  (tail_code),
        .tick_i (tail_tick),
        .zero_o (tail_zero)
    );

    assign eff_sleep = sleep_i & ~irq_pend_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (eff_sleep && lf_en)       state_d = ST_LF_ENTER;
                else if (eff_sleep)           state_d = ST_TAIL;
            end
            ST_TAIL: begin
                if (!eff_sleep)               state_d = ST_RUN;
                else if (lf_en)               state_d = ST_LF_ENTER;
                else if (tail_zero && (!out_q || !gen_lvl))
                                              state_d = ST_OFF;
            end
            ST_OFF: begin
                if (!eff_sleep)               state_d = ST_WAKE;
                else if (lf_en && !lf_s)      state_d = ST_LF;
            end
            ST_WAKE: begin
                if (!gen_lvl)                 state_d = ST_RUN;
            end
            ST_LF_ENTER: begin
                if (!(eff_sleep && lf_en))    state_d = ST_RUN;
                else if (!lf_s && (!out_q || !gen_lvl))
                                              state_d = ST_LF;
            end
            ST_LF: begin
                if (!(eff_sleep && lf_en))    state_d = ST_LF_EXIT;
            end
            ST_LF_EXIT: begin
                if (!gen_lvl && (!out_q || !lf_s))
                                              state_d = ST_RUN;
            end
            default:                          state_d = ST_RUN;
        endcase
    end

    // State and output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_RUN;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    // Output selection follows the state being entered
    always_comb begin
        unique case (src_of(state_d))
            SRC_SEL: out_d = gen_lvl;
            SRC_LF:  out_d = lf_s;
            default: out_d = 1'b0;
        endcase
        osc_en_o  = !(state_q == ST_OFF || state_q == ST_LF);
        tail_load = (state_q != ST_TAIL) && (state_d == ST_TAIL);
        tail_tick = (state_q == ST_TAIL) && out_d && !out_q;
    end

    assign mclk_o = out_q;

    // R9: whenever the driven source changes, the output is low afterwards
    a_r9_switch_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_of(state_d) != src_of(state_q)) |=> !mclk_o);

    // R8: a pending interrupt brings the oscillator enable back by the next cycle
    a_r8_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_pend_i |=> osc_en_o);

    // R5: the oscillator is only released after a sleep without interrupt
    a_r5_osc_needs_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !osc_en_o |-> $past(sleep_i) && !$past(irq_pend_i));

    // R6: gating off from the tail only once the count is exhausted
    a_r6_gate_after_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_OFF) && ($past(state_q) == ST_TAIL) |-> $past(tail_zero));

    // R6: nothing toggles while gated off
    a_r6_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_OFF) && ($past(state_q) == ST_OFF) |-> !mclk_o);

endmodule

// File: tb/mclk_out_ctrl_tb_top.sv
module mclk_out_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lf_clk = 1'b0;
    logic [7:0] ctrl = 8'h06;
    logic       sleep = 1'b0;
    logic       irq = 1'b0;
    logic       mclk_o;
    logic       osc_en_o;

    int checks = 0;
    int errors = 0;

    // codes: control byte, expected high, expected low
    localparam logic [23:0] VEC [0:8] = '{
        24'h00_01_01, 24'h01_02_02, 24'h02_03_03, 24'h03_07_08, 24'h04_0A_0A,
        24'h05_0F_0F, 24'h06_1E_1E, 24'hC6_1E_1E, 24'h41_02_02
    };

    always #4 clk = ~clk;
    always #803 lf_clk = ~lf_clk;

    mclk_out_ctrl dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .lf_clk_i   (lf_clk),
        .ctrl_i     (ctrl),
        .sleep_i    (sleep),
        .irq_pend_i (irq),
        .mclk_o     (mclk_o),
        .osc_en_o   (osc_en_o)
    );

    // Shortest complete high phase seen while enabled (R9)
    logic mon_en = 1'b0;
    logic mon_p, mon_seen;
    int   mon_run, mon_min;
    always @(negedge clk) begin
        if (!mon_en) begin
            mon_seen = 1'b0; mon_min = 1000; mon_run = 0; mon_p = mclk_o;
        end else begin
            if (mclk_o && !mon_p) begin mon_run = 1; mon_seen = 1'b1; end
            else if (mclk_o && mon_seen) mon_run++;
            else if (!mclk_o && mon_p && mon_seen && mon_run < mon_min) mon_min = mon_run;
            mon_p = mclk_o;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rise();
        logic p;
        p = mclk_o;
        forever begin
            @(negedge clk);
            if (mclk_o && !p) break;
            p = mclk_o;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_rise();
        hi = 1;
        forever begin @(negedge clk); if (mclk_o) hi++; else break; end
        lo = 1;
        forever begin @(negedge clk); if (!mclk_o) lo++; else break; end
    endtask

    // Enter sleep and count output rises until the oscillator drops
    task automatic count_tail(output int rises);
        logic p;
        sleep = 1'b1;
        @(negedge clk);
        p = mclk_o;
        rises = 0;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            if (mclk_o && !p) rises++;
            p = mclk_o;
            if (!osc_en_o) break;
        end
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (mclk_o && !p) rises++;
            p = mclk_o;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi, lo, r;
        // R1: reset state
        tick(5);
        chk(mclk_o == 1'b0, "R1 mclk in reset", int'(mclk_o), 0);
        chk(osc_en_o == 1'b1, "R1 osc_en in reset", int'(osc_en_o), 1);
        rst_n = 1'b1;
        tick(1);
        chk(osc_en_o == 1'b1, "R1 osc_en after reset", int'(osc_en_o), 1);

        // R2 / R4: frequency table and ignored top bits
        for (int i = 0; i < 9; i++) begin
            ctrl = VEC[i][23:16];
            repeat (3) measure(hi, lo);
            chk(hi == int'(VEC[i][15:8]), (i >= 7) ? "R4 high phase" : "R2 high phase",
                hi, int'(VEC[i][15:8]));
            chk(lo == int'(VEC[i][7:0]), (i >= 7) ? "R4 low phase" : "R2 low phase",
                lo, int'(VEC[i][7:0]));
        end

        // R3: code 7 passes the low-frequency clock through
        ctrl = 8'h07;
        repeat (2) measure(hi, lo);
        measure(hi, lo);
        chk(hi >= 98 && hi <= 103, "R3 lf high", hi, 100);
        chk(lo >= 98 && lo <= 103, "R3 lf low", lo, 100);

        // R5 / R9: sleep with substitution enabled, then wake
        ctrl = 8'h0E;
        repeat (3) measure(hi, lo);
        mon_en = 1'b1;
        tick(1);
        sleep = 1'b1;
        tick(600);
        chk(osc_en_o == 1'b0, "R5 osc off in lf sleep", int'(osc_en_o), 0);
        measure(hi, lo);
        chk(hi >= 98 && hi <= 103, "R5 lf high in sleep", hi, 100);
        sleep = 1'b0;
        tick(600);
        chk(osc_en_o == 1'b1, "R5 osc on after wake", int'(osc_en_o), 1);
        measure(hi, lo);
        chk(hi == 30 && lo == 30, "R5 selected clock returns", hi, 30);
        mon_en = 1'b0;
        chk(mon_min >= 30, "R9 shortest high phase", mon_min, 30);

        // R6: tail lengths with substitution disabled
        for (int t = 0; t < 4; t++) begin
            ctrl = {4'b0000, 4'b0000} | 8'(t << 4);
            tick(20);
            count_tail(r);
            chk(r == ((t == 0) ? 0 : (128 << (t - 1))), "R6 tail rises", r,
                (t == 0) ? 0 : (128 << (t - 1)));
            chk(osc_en_o == 1'b0 && mclk_o == 1'b0, "R6 gated low", int'(mclk_o), 0);
            sleep = 1'b0;
            tick(20);
        end

        // R7: tail interrupted by wake, then a full tail again
        ctrl = 8'h10;
        tick(10);
        sleep = 1'b1;
        tick(100);
        sleep = 1'b0;
        tick(10);
        chk(osc_en_o == 1'b1, "R7 osc stays on after early wake", int'(osc_en_o), 1);
        count_tail(r);
        chk(r == 128, "R7 tail reloaded", r, 128);
        sleep = 1'b0;
        tick(20);

        // R8: interrupt holds the clock through a sleep request
        irq = 1'b1;
        sleep = 1'b1;
        tick(200);
        chk(osc_en_o == 1'b1, "R8 osc held by irq", int'(osc_en_o), 1);
        measure(hi, lo);
        chk(hi == 1 && lo == 1, "R8 clock runs with irq", hi, 1);
        sleep = 1'b0;
        irq = 1'b0;
        tick(5);
        count_tail(r);
        chk(r == 128, "R8 tail after irq read", r, 128);
        irq = 1'b1;
        tick(2);
        chk(osc_en_o == 1'b1, "R8 irq wakes from off", int'(osc_en_o), 1);
        measure(hi, lo);
        chk(hi == 1 && lo == 1, "R8 clock restarts", lo, 1);
        irq = 1'b0;
        sleep = 1'b0;
        tick(20);

        // R10: code change inside a high phase
        ctrl = 8'h06;
        tick(200);
        wait_rise();
        tick(4);
        ctrl = 8'h00;
        hi = 5;
        forever begin @(negedge clk); if (mclk_o) hi++; else break; end
        chk(hi == 30, "R10 running high phase kept", hi, 30);
        measure(hi, lo);
        chk(hi == 1 && lo == 1, "R10 new code from next low", hi, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule